// File: doc/BRIEF.md
# CPU Core Clock Speed Controller

This block produces the clock enable that paces the CPU core. The enable pulses once every 2^n cycles of the undivided clock, for n from 0 to 7, which gives divide ratios from 1 to 128. The block also drives the clock-source select and the shut-off controls for the main oscillator and the PLL. Only the core is paced by this enable. Timers, the serial engine, external memory and the ADC stay on the undivided clock and never see it.

One 8-bit settings word holds everything. Software cannot write it directly. Only three events change it: a speed command, interrupt entry and interrupt return. On entry, the block saves the active word in a hidden register and loads the word from a separate interrupt-speed register, which software can read and write. On return, a flag carried with the return either restores the saved word or keeps the current one.

A speed command is refused in three cases: flash is busy, the previous cycle also carried a speed command, or the command coincides with an interrupt event. A refused command sets a sticky error flag. Commands and interrupt strobes are plain one-cycle control pulses with no back-pressure. Each command is accepted or refused in the cycle it arrives, so a caller never waits and never retries on its own.

Top module: `cpu_speed_ctrl`

## Requirements
- R1: After reset the settings word and the interrupt-speed register are 0x00, the error flag is low, the source select is 0 and both shut-off outputs are low. The enable is high on every cycle.
- R2: Settings encoding: bits 3:0 give the exponent n for division by 2^n, with values 8 to 15 treated as 7. Bits 5:4 drive the source select (0 main oscillator, 1 real-time oscillator, 2 PLL, 3 passed through unchanged). Bit 6 shuts off the main oscillator and bit 7 shuts off the PLL.
- R3: An accepted speed command loads its operand into the settings word at the next clock edge. From that edge the source select and shut-off outputs follow the new word.
- R4: A speed command is refused in three cases: flash_busy is high, the previous cycle held a speed command, or irq_enter or irq_return is high in the same cycle. A refused command leaves the settings word unchanged (apart from the interrupt event itself) and sets the error flag, which stays high until reset.
- R5: On irq_enter the settings word takes the value of the interrupt-speed register. The previous word is saved in the hidden register.
- R6: On irq_return with the restore flag at 1 the settings word takes the saved value. With the flag at 0 the settings word is unchanged.
- R7: A write to the interrupt-speed register appears on its read port after the next edge and never alters the settings word. An entry in the same cycle uses the old register value.
- R8: With exponent n active, the enable is high for exactly one cycle out of every 2^n.
- R9: A change of exponent takes effect only at the end of the current divided period. The enable pulse that follows the last old-rate pulse comes 2^old cycles after it, and later pulses are 2^new cycles apart.
- R10: When irq_enter and irq_return are high in the same cycle, the entry takes effect and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spd_cmd_valid | input | 1 | One-cycle speed command strobe |
| spd_cmd_op | input | 8 | Speed command operand (settings word) |
| flash_busy | input | 1 | Flash operation in progress; speed commands refused |
| irq_enter | input | 1 | Interrupt entry strobe |
| irq_return | input | 1 | Interrupt return strobe |
| irq_ret_restore | input | 1 | With irq_return: 1 restores the saved word, 0 keeps the current one |
| isr_spd_wr | input | 1 | Write strobe for the interrupt-speed register |
| isr_spd_wdata | input | 8 | Write data for the interrupt-speed register |
| isr_spd_rdata | output | 8 | Read data of the interrupt-speed register |
| cur_spd | output | 8 | Read-only view of the active settings word |
| core_clk_en | output | 1 | Core clock enable, one cycle per divided period |
| clk_src_sel | output | 2 | Clock source select |
| main_osc_off | output | 1 | Main oscillator shut-off |
| pll_off | output | 1 | PLL shut-off |
| spd_cmd_err | output | 1 | Sticky refused-command flag |

## Verification
A wrong settings word or a wrong hidden word shows on cur_spd and on the source and shut-off pins one cycle after the event that produced it. A wrong hidden word therefore shows one cycle after the next restoring return. A wrong divider count or exponent shows only in the spacing of core_clk_en pulses, so a slow setting can hide it for up to 128 cycles. For that reason the bench times several complete periods, and also times the pulse gaps across a mid-period change.

// File: rtl/spd_pkg.sv
package spd_pkg;

  localparam int SPD_WORD_W  = 8;
  localparam int SPD_MAX_EXP = 7;
  localparam logic [SPD_WORD_W-1:0] SPD_RESET_WORD = '0;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_RTC  = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_RSVD = 2'd3
  } spd_src_e;

  typedef struct packed {
    logic       pll_off;
    logic       osc_off;
    logic [1:0] src;
    logic [3:0] div_code;
  } spd_word_t;

endpackage

// File: rtl/spd_cmd_gate.sv
module spd_cmd_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic flash_busy,
  input  logic irq_enter,
  input  logic irq_return,
  output logic accept,
  output logic err
);

  logic cmd_q;
  logic refuse;

  always_comb begin
    refuse = flash_busy | cmd_q | irq_enter | irq_return;
    accept = cmd_valid & ~refuse;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= 1'b0;
      err   <= 1'b0;
    end else begin
      cmd_q <= cmd_valid;
      if (cmd_valid && refuse) err <= 1'b1;
    end
  end

  assert_no_back_to_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !accept);

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: rtl/spd_settings_bank.sv
module spd_settings_bank #(
  parameter int W = spd_pkg::SPD_WORD_W,
  parameter logic [W-1:0] RESET_WORD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic [W-1:0] cmd_op,
  input  logic         irq_enter,
  input  logic         irq_return,
  input  logic         ret_restore,
  input  logic         isr_wr,
  input  logic [W-1:0] isr_wdata,
  output logic [W-1:0] cur,
  output logic [W-1:0] isr_q
);

  logic [W-1:0] saved_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur     <= RESET_WORD;
      isr_q   <= RESET_WORD;
      saved_q <= RESET_WORD;
    end else begin
      if (isr_wr) isr_q <= isr_wdata;
      if (irq_enter) begin
        saved_q <= cur;
        cur     <= isr_q;
      end else if (irq_return) begin
        if (ret_restore) cur <= saved_q;
      end else if (accept) begin
        cur <= cmd_op;
      end
    end
  end

  assert_cur_only_on_events_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !irq_enter && !irq_return) |=> $stable(cur));

  assert_enter_loads_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter |=> cur == $past(isr_q));

  assert_ret_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && ret_restore && !irq_enter) |=> cur == $past(saved_q));

  assert_ret_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && !ret_restore && !irq_enter) |=> $stable(cur));

  assert_enter_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && irq_return) |=> saved_q == $past(cur));

  assert_isr_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    isr_wr |=> isr_q == $past(isr_wdata));

endmodule

// File: rtl/spd_clk_div.sv
module spd_clk_div #(
  parameter int MAX_EXP = spd_pkg::SPD_MAX_EXP,
  localparam int EXP_W = $clog2(MAX_EXP + 1),
  localparam int CNT_W = (MAX_EXP < 1) ? 1 : MAX_EXP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXP_W-1:0] req_exp,
  output logic             clk_en
);

  logic [EXP_W-1:0] act_exp;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit  = CNT_W'((32'd1 << act_exp) - 32'd1);
    clk_en = (cnt == limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_exp <= '0;
    end else if (clk_en) begin
      cnt     <= '0;
      act_exp <= req_exp;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_exp_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(act_exp));

  assert_no_short_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && req_exp != '0) |=> !clk_en);

  assert_div1_every_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && req_exp == '0) |=> clk_en);

endmodule

// File: rtl/cpu_speed_ctrl.sv
module cpu_speed_ctrl #(
  parameter int MAX_EXP = spd_pkg::SPD_MAX_EXP,
  localparam int W = spd_pkg::SPD_WORD_W,
  localparam int EXP_W = $clog2(MAX_EXP + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         spd_cmd_valid,
  input  logic [W-1:0] spd_cmd_op,
  input  logic         flash_busy,
  input  logic         irq_enter,
  input  logic         irq_return,
  input  logic         irq_ret_restore,
  input  logic         isr_spd_wr,
  input  logic [W-1:0] isr_spd_wdata,
  output logic [W-1:0] isr_spd_rdata,
  output logic [W-1:0] cur_spd,
  output logic         core_clk_en,
  output logic [1:0]   clk_src_sel,
  output logic         main_osc_off,
  output logic         pll_off,
  output logic         spd_cmd_err
);

  import spd_pkg::*;

  logic             cmd_accept;
  logic [W-1:0]     cur_word;
  logic [W-1:0]     isr_word;
  spd_word_t        cur_fields;
  logic [EXP_W-1:0] req_exp;

  spd_cmd_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (spd_cmd_valid),
    .flash_busy (flash_busy),
    .irq_enter  (irq_enter),
    .irq_return (irq_return),
    .accept     (cmd_accept),
    .err        (spd_cmd_err)
  );

  spd_settings_bank #(
    .W          (W),
    .RESET_WORD (SPD_RESET_WORD)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (cmd_accept),
    .cmd_op      (spd_cmd_op),
    .irq_enter   (irq_enter),
    .irq_return  (irq_return),
    .ret_restore (irq_ret_restore),
    .isr_wr      (isr_spd_wr),
    .isr_wdata   (isr_spd_wdata),
    .cur         (cur_word),
    .isr_q       (isr_word)
  );

  always_comb begin
    cur_fields = spd_word_t'(cur_word);
    if (32'(cur_fields.div_code) > MAX_EXP) req_exp = EXP_W'(MAX_EXP);
    else                                    req_exp = EXP_W'(cur_fields.div_code);
  end

  spd_clk_div #(
    .MAX_EXP (MAX_EXP)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_exp (req_exp),
    .clk_en  (core_clk_en)
  );

  assign cur_spd       = cur_word;
  assign isr_spd_rdata = isr_word;
  assign clk_src_sel   = cur_fields.src;
  assign main_osc_off  = cur_fields.osc_off;
  assign pll_off       = cur_fields.pll_off;

  assert_busy_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_cmd_valid && flash_busy && !irq_enter && !irq_return) |=> $stable(cur_spd));

  assert_busy_sets_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_cmd_valid && flash_busy) |=> spd_cmd_err);

  assert_accept_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_cmd_valid && !flash_busy && !irq_enter && !irq_return && !$past(spd_cmd_valid))
      |=> cur_spd == $past(spd_cmd_op));

endmodule

// File: tb/cpu_speed_ctrl_tb_top.sv
`timescale 1ns/1ps
module cpu_speed_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       spd_cmd_valid, flash_busy, irq_enter, irq_return, irq_ret_restore, isr_spd_wr;
  logic [7:0] spd_cmd_op, isr_spd_wdata, isr_spd_rdata, cur_spd;
  logic       core_clk_en, main_osc_off, pll_off, spd_cmd_err;
  logic [1:0] clk_src_sel;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  cpu_speed_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .spd_cmd_valid(spd_cmd_valid), .spd_cmd_op(spd_cmd_op),
    .flash_busy(flash_busy), .irq_enter(irq_enter), .irq_return(irq_return),
    .irq_ret_restore(irq_ret_restore), .isr_spd_wr(isr_spd_wr), .isr_spd_wdata(isr_spd_wdata),
    .isr_spd_rdata(isr_spd_rdata), .cur_spd(cur_spd), .core_clk_en(core_clk_en),
    .clk_src_sel(clk_src_sel), .main_osc_off(main_osc_off), .pll_off(pll_off),
    .spd_cmd_err(spd_cmd_err)
  );

  // {operand, expected exponent, expected source, osc off, pll off}
  localparam logic [15:0] VEC [8] = '{
    {8'h02, 4'd2, 2'd0, 1'b0, 1'b0},
    {8'h15, 4'd5, 2'd1, 1'b0, 1'b0},
    {8'h2B, 4'd7, 2'd2, 1'b0, 1'b0},
    {8'h40, 4'd0, 2'd0, 1'b1, 1'b0},
    {8'h83, 4'd3, 2'd0, 1'b0, 1'b1},
    {8'h3F, 4'd7, 2'd3, 1'b0, 1'b0},
    {8'hF1, 4'd1, 2'd3, 1'b1, 1'b1},
    {8'h08, 4'd7, 2'd0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; spd_cmd_valid = 1'b0; spd_cmd_op = '0; flash_busy = 1'b0;
    irq_enter = 1'b0; irq_return = 1'b0; irq_ret_restore = 1'b0;
    isr_spd_wr = 1'b0; isr_spd_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // called at a negedge; returns at the next negedge with the strobe removed
  task automatic issue(input logic [7:0] op);
    spd_cmd_valid = 1'b1; spd_cmd_op = op;
    @(negedge clk);
    spd_cmd_valid = 1'b0;
  endtask

  task automatic pulse_irq(input logic ent, input logic ret, input logic rest);
    irq_enter = ent; irq_return = ret; irq_ret_restore = rest;
    @(negedge clk);
    irq_enter = 1'b0; irq_return = 1'b0; irq_ret_restore = 1'b0;
  endtask

  task automatic wait_pulse();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (core_clk_en) break;
    end
  endtask

  task automatic measure(output int gap);
    wait_pulse();
    gap = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      gap++;
      if (core_clk_en) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int g;
    int cyc;
    do_reset();

    // R1: reset state
    chk("R1 cur", cur_spd, 8'h00);
    chk("R1 isr", isr_spd_rdata, 8'h00);
    chk("R1 err", spd_cmd_err, 0);
    chk("R1 src", clk_src_sel, 0);
    chk("R1 offs", {main_osc_off, pll_off}, 0);
    measure(g);
    chk("R1 R8 gap div1", g, 1);

    // R2 R3 R8: vector walk
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      v = VEC[i];
      @(negedge clk);
      issue(v[15:8]);
      chk("R3 cur", cur_spd, v[15:8]);
      chk("R2 src", clk_src_sel, v[3:2]);
      chk("R2 osc", main_osc_off, v[1]);
      chk("R2 pll", pll_off, v[0]);
      measure(g);
      measure(g);
      chk("R2 R8 gap", g, 32'd1 << v[7:4]);
    end
    chk("R3 no err", spd_cmd_err, 0);

    // R9: mid-period change from /8 to /4
    @(negedge clk);
    issue(8'h03);
    measure(g);
    wait_pulse();
    @(negedge clk); @(negedge clk);
    issue(8'h02);
    cyc = 3;
    for (int k = 0; k < 40; k++) begin
      if (core_clk_en) break;
      @(negedge clk);
      cyc++;
    end
    chk("R9 old period completes", cyc, 8);
    measure(g);
    chk("R9 new gap", g, 4);

    // R4: flash busy refusal
    do_reset();
    flash_busy = 1'b1;
    issue(8'h55);
    flash_busy = 1'b0;
    chk("R4 busy cur", cur_spd, 8'h00);
    chk("R4 busy err", spd_cmd_err, 1);
    repeat (5) @(negedge clk);
    chk("R4 err sticky", spd_cmd_err, 1);

    // R4: back-to-back refusal
    do_reset();
    spd_cmd_valid = 1'b1; spd_cmd_op = 8'h12;
    @(negedge clk);
    spd_cmd_op = 8'h23;
    @(negedge clk);
    spd_cmd_valid = 1'b0;
    chk("R4 b2b cur", cur_spd, 8'h12);
    chk("R4 b2b err", spd_cmd_err, 1);

    // R7 R5 R6 R10: interrupt path
    do_reset();
    issue(8'h83);
    isr_spd_wr = 1'b1; isr_spd_wdata = 8'h25;
    @(negedge clk);
    isr_spd_wr = 1'b0;
    chk("R7 isr read", isr_spd_rdata, 8'h25);
    chk("R7 cur untouched", cur_spd, 8'h83);
    pulse_irq(1'b1, 1'b0, 1'b0);
    chk("R5 enter cur", cur_spd, 8'h25);
    chk("R5 enter src", clk_src_sel, 2);
    pulse_irq(1'b0, 1'b1, 1'b1);
    chk("R6 restore", cur_spd, 8'h83);
    pulse_irq(1'b1, 1'b0, 1'b0);
    pulse_irq(1'b0, 1'b1, 1'b0);
    chk("R6 keep", cur_spd, 8'h25);
    issue(8'h83);
    @(negedge clk);
    pulse_irq(1'b1, 1'b1, 1'b1);
    chk("R10 enter wins", cur_spd, 8'h25);
    pulse_irq(1'b0, 1'b1, 1'b1);
    chk("R10 saved old", cur_spd, 8'h83);
    chk("R5 no err so far", spd_cmd_err, 0);

    // R4: command coinciding with entry
    @(negedge clk);
    spd_cmd_valid = 1'b1; spd_cmd_op = 8'h07; irq_enter = 1'b1;
    @(negedge clk);
    spd_cmd_valid = 1'b0; irq_enter = 1'b0;
    chk("R4 irq clash cur", cur_spd, 8'h25);
    chk("R4 irq clash err", spd_cmd_err, 1);

    // R7: write and entry in the same cycle uses old value
    do_reset();
    isr_spd_wr = 1'b1; isr_spd_wdata = 8'h31; irq_enter = 1'b1;
    @(negedge clk);
    isr_spd_wr = 1'b0; irq_enter = 1'b0;
    chk("R7 same-cycle old", cur_spd, 8'h00);
    chk("R7 same-cycle new rd", isr_spd_rdata, 8'h31);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule